// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block is a byte-wide streaming stage placed between the source of transmit frame bytes and the serializer that drives the medium. Frame bytes from the destination address onward enter on a valid/ready interface with an end-of-frame marker. They leave on a matching output interface with zero added latency while data is flowing. The preamble and start-of-frame delimiter are not generated here. They are treated as eight bytes already on the wire when the frame starts, so the minimum of 544 bits before the check sequence is met when the frame body reaches 60 bytes.

When automatic padding is enabled and a frame ends short, the block extends the body with zero bytes up to the minimum and then appends the 32-bit frame check sequence. Padding always forces the check sequence to be added. Without padding, the sequence is added only when the global disable input is low and the frame's own add flag is set. Runt frames then pass through untouched. The pad length comes only from the count of bytes actually sent. Any length/type field inside the frame is never consulted.

The controller has three states. DATA passes input bytes through. It moves to PAD when a frame ends short with padding active, to FCS when a frame ends at or above the minimum and needs a check sequence, and otherwise stays in DATA. PAD emits zero bytes and moves to FCS once the body count reaches 60. FCS emits four check bytes and returns to DATA after the last one.

Top module: `eth_tx_padfcs`

## Requirements
- R1: After reset, with no input offered, out_valid is 0 and in_ready equals out_ready; the block is waiting for the first byte of a frame.
- R2: In the data phase each accepted input byte appears on the output in the same cycle, unchanged and in order, and in_ready equals out_ready.
- R3: With padding sampled on, a frame whose body is shorter than 60 bytes is followed by 00h bytes until the body is exactly 60 bytes, and the check sequence comes after the pad.
- R4: With padding sampled on, the 4-byte check sequence is appended whatever the values of cfg_fcs_disable and in_add_fcs.
- R5: With padding sampled off, no pad byte is inserted, and frames shorter than 60 bytes leave the block with their original length.
- R6: With padding sampled off, the check sequence is appended exactly when cfg_fcs_disable is 0 and in_add_fcs is 1.
- R7: The check sequence is the reflected CRC-32 (reflected polynomial EDB88320h, preset all ones, result complemented) over data and pad bytes. It is sent least significant byte first, so the x^31 coefficient is the first bit on the wire. For the body "123456789" the four bytes are 26h 39h F4h CBh.
- R8: out_last is 1 on exactly one byte per frame, the final byte: the last check byte when one is added, otherwise the last data byte.
- R9: With padding on, a body of 60 bytes or more gets no pad and is followed directly by the check sequence.
- R10: cfg_auto_pad, cfg_fcs_disable and in_add_fcs are sampled with the first byte of a frame; changes later in the frame have no effect on that frame.
- R11: While pad or check bytes are being sent, in_ready is 0. A stalled output holds its byte and no byte is lost or repeated.
- R12: A length/type field inside the frame that claims a longer body does not change the pad count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_pad | input | 1 | Enable padding to the minimum size (reset default of the driving register is 0) |
| cfg_fcs_disable | input | 1 | Global check-sequence disable when padding is off (default 0) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Input byte is the last data byte of the frame |
| in_add_fcs | input | 1 | Per-frame request to append the check sequence |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final byte of the frame |

## Verification
A wrong state or counter shows at the ports within one frame. A bad body count changes the output frame length, seen at the end marker. A lost frame-start flag makes a following frame take the wrong pad or check decision. A corrupted CRC register shows in the four check bytes of the very frame it touched. Directed frames are compared byte for byte against a model built in the bench. The model covers bodies around the 60-byte boundary, each flag combination, flag changes in mid-frame and output stalls. A known-answer check sequence anchors the CRC bit ordering.

// File: rtl/eth_padfcs_pkg.sv
package eth_padfcs_pkg;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_FCS  = 2'd2
    } pf_state_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam int          FCS_BYTES     = 4;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  byte_in);
        logic [31:0] c;
        c = crc_in ^ {24'd0, byte_in};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/eth_fcs_acc.sv
module eth_fcs_acc
    import eth_padfcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] fcs_word
);

    logic [31:0] crc_q;
    logic [31:0] crc_base;

    always_comb begin
        crc_base = restart ? 32'hFFFF_FFFF : crc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= 32'hFFFF_FFFF;
        end else if (step) begin
            crc_q <= crc32_step(crc_base, din);
        end
    end

    assign fcs_word = ~crc_q;

endmodule

// File: rtl/eth_body_count.sv
module eth_body_count #(
    parameter int LIMIT = 60,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_after
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        cnt_base  = restart ? '0 : cnt_q;
        cnt_after = (cnt_base >= LIMIT_C) ? LIMIT_C : cnt_base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_after;
        end
    end

endmodule

// File: rtl/eth_tx_padfcs.sv
module eth_tx_padfcs
    import eth_padfcs_pkg::*;
#(
    parameter int MIN_FRAME_BITS = 544,
    parameter int PRE_BYTES      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_auto_pad,
    input  logic       cfg_fcs_disable,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_add_fcs,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);

    localparam int BODY_MIN = MIN_FRAME_BITS / 8 - PRE_BYTES;
    localparam int CNT_W    = $clog2(BODY_MIN + 1);
    localparam int IDX_W    = $clog2(FCS_BYTES);
    localparam logic [CNT_W-1:0] BODY_MIN_C = CNT_W'(BODY_MIN);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(FCS_BYTES - 1);

    pf_state_e        st_q, st_d;
    logic             sof_q;
    logic             pad_q, fcs_q;
    logic [IDX_W-1:0] idx_q;

    logic             pad_eff, fcs_eff, need_pad;
    logic             in_fire, out_fire, acc_step;
    logic [CNT_W-1:0] cnt_after;
    logic [31:0]      fcs_word;

    // Per-frame decisions: live on the first byte, held afterwards.
    always_comb begin
        pad_eff  = sof_q ? cfg_auto_pad : pad_q;
        fcs_eff  = sof_q ? (cfg_auto_pad | (~cfg_fcs_disable & in_add_fcs)) : fcs_q;
        need_pad = pad_eff && (cnt_after < BODY_MIN_C);
        in_fire  = in_valid && in_ready;
        out_fire = out_valid && out_ready;
        acc_step = out_fire && (st_q != ST_FCS);
    end

    eth_fcs_acc u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (sof_q),
        .step     (acc_step),
        .din      (out_data),
        .fcs_word (fcs_word)
    );

    eth_body_count #(.LIMIT(BODY_MIN)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (sof_q),
        .step      (acc_step),
        .cnt_after (cnt_after)
    );

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DATA: begin
                if (in_fire && in_last) begin
                    if (need_pad)     st_d = ST_PAD;
                    else if (fcs_eff) st_d = ST_FCS;
                    else              st_d = ST_DATA;
                end
            end
            ST_PAD: begin
                if (out_fire && (cnt_after >= BODY_MIN_C)) st_d = ST_FCS;
            end
            ST_FCS: begin
                if (out_fire && (idx_q == IDX_LAST)) st_d = ST_DATA;
            end
            default: st_d = ST_DATA;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_DATA;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        in_ready  = 1'b0;
        unique case (st_q)
            ST_DATA: begin
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last && !need_pad && !fcs_eff;
                in_ready  = out_ready;
            end
            ST_PAD: begin
                out_valid = 1'b1;
                out_data  = 8'h00;
            end
            ST_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_word[{idx_q, 3'b000} +: 8];
                out_last  = (idx_q == IDX_LAST);
            end
            default: ;
        endcase
    end

    // Frame bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_q <= 1'b1;
            pad_q <= 1'b0;
            fcs_q <= 1'b0;
            idx_q <= '0;
        end else begin
            if (in_fire) begin
                if (sof_q) begin
                    pad_q <= pad_eff;
                    fcs_q <= fcs_eff;
                end
                sof_q <= in_last && !need_pad && !fcs_eff;
            end else if ((st_q == ST_FCS) && out_fire && (idx_q == IDX_LAST)) begin
                sof_q <= 1'b1;
            end
            if ((st_q == ST_FCS) && out_fire) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/eth_tx_padfcs_chk.sv
module eth_tx_padfcs_chk
    import eth_padfcs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input pf_state_e  st
);

    // R11
    input_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA) |-> !in_ready);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_DATA && out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(st)));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |-> (out_valid && out_data == 8'h00 && !out_last));

    // R4
    pad_to_fcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_PAD && st != ST_PAD) |-> (st == ST_FCS));

    // R8
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (st == ST_DATA));

endmodule

bind eth_tx_padfcs eth_tx_padfcs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .st        (st_q)
);

// File: tb/eth_tx_padfcs_bench.sv
`timescale 1ns/100ps
module eth_tx_padfcs_bench;

    typedef logic [7:0] b_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_pad = 1'b0, cfg_fcs_disable = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_add_fcs = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_last;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    b_t   got_q[$];
    bit   lst_q[$];
    bit   leak;

    always #2.5 clk = ~clk;

    eth_tx_padfcs u_eth_tx_padfcs (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_pad(cfg_auto_pad), .cfg_fcs_disable(cfg_fcs_disable),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_add_fcs(in_add_fcs),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input b_t d[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (d[i]) begin
            c ^= {24'd0, d[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic void make_body(ref b_t d[$], input int n, input int seed);
        d = {};
        for (int i = 0; i < n; i++) d.push_back(b_t'((seed + i * 7) & 255));
    endfunction

    task automatic run_frame(input b_t d[$], input bit ap, input bit dis,
                             input bit add, input bit flip, input bit stall);
        int idx = 0;
        int cyc = 0;
        bit done = 0;
        bit in_done = 0;
        int n = d.size();
        got_q = {};
        lst_q = {};
        leak  = 0;
        cfg_auto_pad = ap;
        cfg_fcs_disable = dis;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            in_valid   = (idx < n);
            in_data    = (idx < n) ? d[idx] : 8'h00;
            in_last    = (idx == n - 1);
            in_add_fcs = flip && idx >= 1 ? ~add : add;
            if (flip && idx >= 1) begin
                cfg_auto_pad    = ~ap;
                cfg_fcs_disable = ~dis;
            end
            out_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (in_done && in_ready) leak = 1;
            if (out_valid && out_ready) begin
                got_q.push_back(out_data);
                lst_q.push_back(out_last);
                if (out_last) done = 1;
            end
            if (in_valid && in_ready) begin
                if (idx == n - 1) in_done = 1;
                idx++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        out_ready = 1'b1;
        if (!done) chk("R8", "frame never ended", 0, 1);
    endtask

    task automatic compare(input string req, input b_t d[$], input bit ap,
                           input bit dis, input bit add);
        b_t exp[$];
        logic [31:0] f;
        int mism = 0;
        int nlast = 0;
        exp = d;
        if (ap) while (exp.size() < 60) exp.push_back(8'h00);
        if (ap || (!dis && add)) begin
            f = ref_crc(exp);
            for (int k = 0; k < 4; k++) exp.push_back(f[8*k +: 8]);
        end
        chk(req, "length", got_q.size(), exp.size());
        foreach (exp[i]) if (i >= got_q.size() || got_q[i] !== exp[i]) mism++;
        chk(req, "byte mismatches", mism, 0);
        foreach (lst_q[i]) if (lst_q[i]) nlast++;
        // R8 end marker only on the final byte
        chk("R8", "last marker count", nlast, 1);
        if (lst_q.size() > 0) chk("R8", "last on final byte", lst_q[lst_q.size()-1], 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk("R1", "out_valid idle", out_valid, 0);
        chk("R1", "in_ready idle", in_ready, 1);
    endtask

    task automatic t_runt();
        b_t d[$];
        make_body(d, 10, 3);
        run_frame(d, 0, 1, 1, 0, 0);
        compare("R5", d, 0, 1, 1);
        compare("R2", d, 0, 1, 1);
    endtask

    task automatic t_known();
        b_t d[$];
        int n;
        d = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        run_frame(d, 0, 0, 1, 0, 0);
        compare("R6", d, 0, 0, 1);
        n = got_q.size();
        if (n == 13) begin
            chk("R7", "fcs byte0", got_q[9],  8'h26);
            chk("R7", "fcs byte1", got_q[10], 8'h39);
            chk("R7", "fcs byte2", got_q[11], 8'hF4);
            chk("R7", "fcs byte3", got_q[12], 8'hCB);
        end else chk("R7", "known frame length", n, 13);
    endtask

    task automatic t_pad_short();
        b_t d[$];
        make_body(d, 20, 11);
        d[12] = 8'h00;
        d[13] = 8'h2E;  // R12: length field claims 46 bytes
        run_frame(d, 1, 1, 0, 0, 0);
        compare("R3", d, 1, 1, 0);
        chk("R4", "fcs forced total", got_q.size(), 64);
        if (got_q.size() > 20) chk("R12", "first pad byte", got_q[20], 8'h00);
    endtask

    task automatic t_boundary();
        b_t d[$];
        make_body(d, 59, 5);
        run_frame(d, 1, 0, 0, 0, 0);
        compare("R3", d, 1, 0, 0);
        make_body(d, 60, 9);
        run_frame(d, 1, 1, 0, 0, 0);
        compare("R9", d, 1, 1, 0);
        make_body(d, 61, 2);
        run_frame(d, 1, 0, 1, 0, 0);
        compare("R9", d, 1, 0, 1);
        make_body(d, 1, 77);
        run_frame(d, 1, 1, 1, 0, 0);
        compare("R3", d, 1, 1, 1);
    endtask

    task automatic t_long();
        b_t d[$];
        make_body(d, 70, 21);
        run_frame(d, 1, 1, 0, 0, 0);
        compare("R9", d, 1, 1, 0);
    endtask

    task automatic t_fcs_flag();
        b_t d[$];
        make_body(d, 30, 40);
        run_frame(d, 0, 0, 0, 0, 0);
        compare("R6", d, 0, 0, 0);
        run_frame(d, 0, 0, 1, 0, 0);
        compare("R6", d, 0, 0, 1);
        run_frame(d, 0, 1, 1, 0, 0);
        compare("R6", d, 0, 1, 1);
    endtask

    task automatic t_midflip();
        b_t d[$];
        make_body(d, 10, 60);
        run_frame(d, 0, 1, 0, 1, 0);
        compare("R10", d, 0, 1, 0);
        run_frame(d, 1, 0, 1, 1, 0);
        compare("R10", d, 1, 0, 1);
    endtask

    task automatic t_stall();
        b_t d[$];
        make_body(d, 25, 90);
        run_frame(d, 1, 0, 0, 0, 1);
        compare("R11", d, 1, 0, 0);
        chk("R11", "in_ready during pad/fcs", leak, 0);
        make_body(d, 40, 13);
        run_frame(d, 0, 0, 1, 0, 1);
        compare("R2", d, 0, 0, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_runt();
        t_known();
        t_pad_short();
        t_boundary();
        t_long();
        t_fcs_flag();
        t_midflip();
        t_stall();
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule